// File: doc/BRIEF.md
# Platform Status and Control Register Block

This block is a small 32-bit register file on a simple request bus. It lets system software identify the board and read its clock and memory configuration. It also gives software a way to ask for a full system reset. Most words are hard-wired status encodings. One word, the clock-divider word, packs in the live reference timer frequency, and another packs in the installed memory size. Both values come in on input pins.

Each request lasts one cycle, and the block takes a new request in every cycle. An accepted read produces `rd_valid` together with the data on the next cycle. A qualifying write to the control word produces a one-cycle `sys_reset_req` pulse on the next cycle. Only full-word accesses are honoured. Decoding looks at the low 16 address bits only.

A three-state machine sequences the responses:
- `ST_IDLE`: no response.
- `ST_RD_RESP`: read data is presented.
- `ST_RST_PULSE`: the reset request is asserted.

The next state follows from the request in the current cycle, and it does not depend on the current state. Every state can move to any state:
- A read moves to `ST_RD_RESP`.
- A reset-requesting write moves to `ST_RST_PULSE`.
- Anything else moves to `ST_IDLE`.

Top module: `plat_status_regs`

## Requirements
- R1: Size codes are 0 for one byte, 1 for two bytes, 2 for four bytes and 3 for eight bytes. Only size code 2 is honoured. A read of any other size returns 0, and a write of any other size has no effect.
- R2: Only `req_addr[15:0]` selects a word. Bits above 15 have no effect on the data returned or on the reset request.
- R3: Offsets 0x00, 0x04 and 0x08 read as 0x00000000.
- R4: Offset 0x14 reads as 0x00000005, with bit 0 (memory locked) and bit 2 (memory calibrated) set.
- R5: Offset 0x30 reads as follows. Bits [7:0] are 1. Bits [15:8] are `ref_mhz` as sampled with the request. Bits [23:16] are 1. Bits [31:24] are 1.
- R6: Offset 0x34 reads as 0x0000000E. Bits 1 to 3 are set, which means three PCIe ports are present. Bit 0, which means I/O coherence, is clear.
- R7: Offset 0x38 reads with bits [3:0] equal to `mem_gib`, bits [15:4] all ones and bits [31:16] clear.
- R8: Every other offset reads as 0, including 0x10 and 0x18.
- R9: A four-byte write to offset 0x10 with `req_wdata[4]` set raises `sys_reset_req` for exactly the cycle after the write. Back-to-back writes of this kind keep it high for one cycle each.
- R10: A write gives no `rd_valid`. Writes to read-only offsets, to 0x10 with bit 4 clear, and to any other offset raise no reset request and leave every later read value unchanged.
- R11: `rd_valid` is high exactly in the cycle after an accepted read. While `rd_valid` is low, `rd_data` is 0.
- R12: While `rst_n` is low, `rd_valid`, `rd_data` and `sys_reset_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address; only bits [15:0] decoded |
| req_size | input | 2 | Access size code (0:1B, 1:2B, 2:4B, 3:8B) |
| req_wdata | input | 32 | Write data |
| ref_mhz | input | 8 | Reference timer frequency in MHz |
| mem_gib | input | 4 | Installed memory size in GiB |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read response data |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
The bench goes after the following corner cases:
- Reads and writes of every non-word size. A design that ignored the size would return status words on byte reads, or would fire a reset on a byte write.
- Addresses that alias through the upper sixteen bits. A design that decoded too many address bits would read zero at these aliases.
- Control-word writes with bit 4 clear, and writes of bit 4 to read-only offsets. A design with a loose decode would pulse reset on these.
- Back-to-back reset writes, and a read right after a write. A design that stretched or merged its pulse, or leaked stale read data, would fail these.
- Changes to the frequency and memory-size inputs between reads. A design that latched these inputs once would show the old values.

// File: rtl/plat_regs_pkg.sv
package plat_regs_pkg;

    localparam int DATA_W = 32;
    localparam int OFFS_W = 16;

    typedef enum logic [1:0] {
        SZ_1B = 2'd0,
        SZ_2B = 2'd1,
        SZ_4B = 2'd2,
        SZ_8B = 2'd3
    } acc_size_e;

    // Word offsets whose position other logic depends on
    localparam logic [OFFS_W-1:0] OFF_IDENT   = 16'h0000;
    localparam logic [OFFS_W-1:0] OFF_CORE_ID = 16'h0004;
    localparam logic [OFFS_W-1:0] OFF_WRAP_ID = 16'h0008;
    localparam logic [OFFS_W-1:0] OFF_CTRL    = 16'h0010;
    localparam logic [OFFS_W-1:0] OFF_MEMSTAT = 16'h0014;
    localparam logic [OFFS_W-1:0] OFF_CLKDIV  = 16'h0030;
    localparam logic [OFFS_W-1:0] OFF_BUILD   = 16'h0034;
    localparam logic [OFFS_W-1:0] OFF_MEMCFG  = 16'h0038;

    localparam int CTRL_RESET_BIT = 4;

    localparam logic [DATA_W-1:0] MEMSTAT_WORD = 32'h0000_0005;
    localparam logic [DATA_W-1:0] BUILD_WORD   = 32'h0000_000E;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_RD_RESP   = 2'd1,
        ST_RST_PULSE = 2'd2
    } acc_state_e;

endpackage

// File: rtl/plat_reg_decode.sv
module plat_reg_decode
    import plat_regs_pkg::*;
#(
    parameter int FREQ_W = 8,
    parameter int GIB_W  = 4
) (
    input  logic [OFFS_W-1:0] offset,
    input  logic              size_ok,
    input  logic [FREQ_W-1:0] ref_mhz,
    input  logic [GIB_W-1:0]  mem_gib,
    output logic [DATA_W-1:0] word
);
    localparam int LANE_W  = 8;
    localparam int N_LANES = DATA_W / LANE_W;
    localparam int MHZ_LANE = 1;
    localparam int ONES_W  = 12;

    logic [DATA_W-1:0] clkdiv_word;
    logic [DATA_W-1:0] memcfg_word;

    // Clock divider word: every lane holds 1 except the frequency lane
    for (genvar g = 0; g < N_LANES; g++) begin : g_clk_lane
        if (g == MHZ_LANE) begin : g_mhz
            assign clkdiv_word[g*LANE_W +: LANE_W] = LANE_W'(ref_mhz);
        end else begin : g_one
            assign clkdiv_word[g*LANE_W +: LANE_W] = LANE_W'(1);
        end
    end

    assign memcfg_word = DATA_W'({{ONES_W{1'b1}}, mem_gib});

    always_comb begin
        word = '0;
        if (size_ok) begin
            unique case (offset)
                OFF_MEMSTAT: word = MEMSTAT_WORD;
                OFF_CLKDIV:  word = clkdiv_word;
                OFF_BUILD:   word = BUILD_WORD;
                OFF_MEMCFG:  word = memcfg_word;
                default:     word = '0;
            endcase
        end
    end

endmodule

// File: rtl/plat_access_fsm.sv
module plat_access_fsm
    import plat_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_read,
    input  logic              acc_rst,
    input  logic [DATA_W-1:0] rd_word,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              sys_reset_req
);
    acc_state_e        state_q, state_d;
    logic [DATA_W-1:0] data_q;

    always_comb begin
        state_d = ST_IDLE;
        if (acc_read)     state_d = ST_RD_RESP;
        else if (acc_rst) state_d = ST_RST_PULSE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            data_q  <= acc_read ? rd_word : '0;
        end
    end

    always_comb begin
        rd_valid      = 1'b0;
        rd_data       = '0;
        sys_reset_req = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RD_RESP: begin
                rd_valid = 1'b1;
                rd_data  = data_q;
            end
            ST_RST_PULSE: sys_reset_req = 1'b1;
            default: ;
        endcase
    end

    assert_pulse_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |-> $past(acc_rst));

    assert_resp_after_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(acc_read));

    assert_idle_data_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0));

    assert_exclusive_outputs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && sys_reset_req));

endmodule

// File: rtl/plat_status_regs.sv
module plat_status_regs
    import plat_regs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int FREQ_W = 8,
    parameter int GIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    input  logic [FREQ_W-1:0] ref_mhz,
    input  logic [GIB_W-1:0]  mem_gib,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    output logic              sys_reset_req
);
    logic [OFFS_W-1:0] offset;
    logic              size_ok;
    logic              acc_read;
    logic              acc_rst;
    logic [DATA_W-1:0] rd_word;
    logic              unused_bits;

    assign offset   = req_addr[OFFS_W-1:0];
    assign size_ok  = (acc_size_e'(req_size) == SZ_4B);
    assign acc_read = req_valid && !req_write;
    assign acc_rst  = req_valid && req_write && size_ok &&
                      (offset == OFF_CTRL) && req_wdata[CTRL_RESET_BIT];
    assign unused_bits = ^{req_addr[ADDR_W-1:OFFS_W], req_wdata};

    plat_reg_decode #(
        .FREQ_W (FREQ_W),
        .GIB_W  (GIB_W)
    ) u_decode (
        .offset  (offset),
        .size_ok (size_ok),
        .ref_mhz (ref_mhz),
        .mem_gib (mem_gib),
        .word    (rd_word)
    );

    plat_access_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .acc_read      (acc_read),
        .acc_rst       (acc_rst),
        .rd_word       (rd_word),
        .rd_valid      (rd_valid),
        .rd_data       (rd_data),
        .sys_reset_req (sys_reset_req)
    );

    assert_bad_size_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(req_size != 2'd2)) |-> (rd_data == '0));

    assert_memstat_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(req_addr[15:0] == 16'h0014 && req_size == 2'd2))
        |-> (rd_data == 32'h0000_0005));

    assert_clkdiv_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(req_addr[15:0] == 16'h0030 && req_size == 2'd2))
        |-> (rd_data[31:16] == 16'h0101 && rd_data[7:0] == 8'h01 &&
             rd_data[15:8] == 8'($past(ref_mhz))));

    assert_write_no_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> !rd_valid);

    assert_no_pulse_bad_size_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_size != 2'd2) |=> !sys_reset_req);

endmodule

// File: tb/test_plat_status_regs.sv
`timescale 1ns/1ps
module test_plat_status_regs;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_write;
    logic [31:0] req_addr;
    logic [1:0]  req_size;
    logic [31:0] req_wdata;
    logic [7:0]  ref_mhz;
    logic [3:0]  mem_gib;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        sys_reset_req;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic        q_v[$];
    logic [31:0] q_d[$];
    logic        q_r[$];
    string       q_tag[$];

    always #2.5 clk = ~clk;

    plat_status_regs i_plat_status_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .req_size      (req_size),
        .req_wdata     (req_wdata),
        .ref_mhz       (ref_mhz),
        .mem_gib       (mem_gib),
        .rd_valid      (rd_valid),
        .rd_data       (rd_data),
        .sys_reset_req (sys_reset_req)
    );

    // Reference model of a read, from the requirements
    function automatic logic [31:0] model_read(logic [31:0] a, logic [1:0] sz,
                                               logic [7:0] mhz, logic [3:0] gib);
        if (sz != 2'd2) return 32'h0;                       // R1
        case (a[15:0])                                       // R2
            16'h0014: return 32'h0000_0005;                  // R4
            16'h0030: return {8'h01, 8'h01, mhz, 8'h01};     // R5
            16'h0034: return 32'h0000_000E;                  // R6
            16'h0038: return {16'h0, 12'hFFF, gib};          // R7
            default:  return 32'h0;                          // R3, R8
        endcase
    endfunction

    task automatic do_req(input logic v, input logic w, input logic [31:0] a,
                          input logic [1:0] sz, input logic [31:0] wd, input string tag);
        logic ev;
        @(negedge clk);
        req_valid = v; req_write = w; req_addr = a; req_size = sz; req_wdata = wd;
        ev = v && !w;
        q_v.push_back(ev);
        q_d.push_back(ev ? model_read(a, sz, ref_mhz, mem_gib) : 32'h0);
        q_r.push_back(v && w && sz == 2'd2 && a[15:0] == 16'h0010 && wd[4]);
        q_tag.push_back(tag);
    endtask

    task automatic rd(input logic [31:0] a, input logic [1:0] sz, input string tag);
        do_req(1'b1, 1'b0, a, sz, 32'h0, tag);
    endtask

    task automatic wr(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] wd,
                      input string tag);
        do_req(1'b1, 1'b1, a, sz, wd, tag);
    endtask

    task automatic idle(input string tag);
        do_req(1'b0, 1'b0, 32'h0, 2'd2, 32'h0, tag);
    endtask

    // Monitor: compares each registered response with the queued expectation
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_v.size() > 0) begin
                logic ev, er;
                logic [31:0] ed;
                string t;
                ev = q_v.pop_front(); ed = q_d.pop_front();
                er = q_r.pop_front(); t = q_tag.pop_front();
                checks++;
                if (rd_valid !== ev || rd_data !== ed || sys_reset_req !== er) begin
                    errors++;
                    $display("FAIL %s: got v=%0b d=%08h rst=%0b, expected v=%0b d=%08h rst=%0b",
                             t, rd_valid, rd_data, sys_reset_req, ev, ed, er);
                end
            end
        end
    end

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        req_size = 2'd2; req_wdata = '0; ref_mhz = 8'd25; mem_gib = 4'd1;
        repeat (3) @(negedge clk);
        checks++;
        if (rd_valid !== 1'b0 || rd_data !== 32'h0 || sys_reset_req !== 1'b0) begin
            errors++;
            $display("FAIL R12 reset: got v=%0b d=%08h rst=%0b, expected 0 0 0",
                     rd_valid, rd_data, sys_reset_req);
        end
        rst_n = 1'b1;

        idle("R11 idle");
        rd(32'h0000_0000, 2'd2, "R3 ident");
        rd(32'h0000_0004, 2'd2, "R3 core id");
        rd(32'h0000_0008, 2'd2, "R3 wrapper id");
        rd(32'h0000_0014, 2'd2, "R4 memstat");
        rd(32'h0000_0030, 2'd2, "R5 clkdiv");
        rd(32'h0000_0034, 2'd2, "R6 build");
        rd(32'h0000_0038, 2'd2, "R7 memcfg");
        rd(32'h0000_0010, 2'd2, "R8 ctrl reads 0");
        rd(32'h0000_0018, 2'd2, "R8 pcie status");
        rd(32'h0000_0ffc, 2'd2, "R8 unlisted");
        rd(32'hABCD_0014, 2'd2, "R2 alias memstat");
        rd(32'h1234_0038, 2'd2, "R2 alias memcfg");
        for (int s = 0; s < 4; s++) begin
            if (s != 2) rd(32'h0000_0014, 2'(s), "R1 narrow read");
        end
        rd(32'h0000_0030, 2'd3, "R1 wide read");

        // live inputs
        @(negedge clk); ref_mhz = 8'd100; mem_gib = 4'd2;
        idle("R11 idle");
        rd(32'h0000_0030, 2'd2, "R5 clkdiv 100MHz");
        rd(32'h0000_0038, 2'd2, "R7 memcfg 2GiB");
        @(negedge clk); ref_mhz = 8'hFF; mem_gib = 4'hF;
        idle("R11 idle");
        rd(32'h0000_0030, 2'd2, "R5 clkdiv max");
        rd(32'h0000_0038, 2'd2, "R7 memcfg max");

        // reset request
        wr(32'h0000_0010, 2'd2, 32'h0000_0010, "R9 reset write");
        idle("R9 pulse ends");
        wr(32'h0000_0010, 2'd2, 32'hFFFF_FFFF, "R9 back to back 1");
        wr(32'hFFFF_0010, 2'd2, 32'h0000_0010, "R9 R2 back to back 2");
        rd(32'h0000_0014, 2'd2, "R11 read after write");
        wr(32'h0000_0010, 2'd2, 32'hFFFF_FFEF, "R10 bit4 clear");
        wr(32'h0000_0010, 2'd0, 32'h0000_0010, "R1 byte reset write");
        wr(32'h0000_0010, 2'd1, 32'h0000_0010, "R1 half reset write");
        wr(32'h0000_0010, 2'd3, 32'h0000_0010, "R1 dword reset write");
        wr(32'h0000_0014, 2'd2, 32'hFFFF_FFFF, "R10 ro memstat write");
        wr(32'h0000_0030, 2'd2, 32'h0000_0000, "R10 ro clkdiv write");
        wr(32'h0000_0034, 2'd2, 32'h0000_0000, "R10 ro build write");
        wr(32'h0000_0038, 2'd2, 32'h0000_0000, "R10 ro memcfg write");
        wr(32'h0000_0000, 2'd2, 32'hFFFF_FFFF, "R10 ro ident write");
        wr(32'h0000_0018, 2'd2, 32'hFFFF_FFFF, "R10 pcie write");
        wr(32'h0001_0000, 2'd2, 32'h0000_0010, "R2 R10 offset 0 write");
        rd(32'h0000_0014, 2'd2, "R10 memstat kept");
        rd(32'h0000_0030, 2'd2, "R10 clkdiv kept");
        rd(32'h0000_0034, 2'd2, "R10 build kept");
        rd(32'h0000_0038, 2'd2, "R10 memcfg kept");
        rd(32'h0000_0000, 2'd2, "R10 ident kept");
        idle("R11 idle");
        idle("R11 idle");
        @(negedge clk); req_valid = 1'b0;
        while (q_v.size() > 0) @(negedge clk);
        finish_run();
    end

endmodule